// File: doc/BRIEF.md
# ECC Error Trace and Diagnostics Monitor

This block sits beside a SECDED decoder and turns its per-access error pulses into history and statistics that software can inspect. Each cycle the decoder may report a corrected single-bit error, a detected double-bit error and/or an address error, together with the address of the access. Corrected-error addresses are kept in a short trace FIFO. That FIFO refuses an address it already holds, so one weak location cannot flood it. Uncorrectable events (double-error detections and address errors) go into a second trace FIFO.

Three saturating counters tally the three event kinds. Each counter has its own programmable threshold, and a threshold output goes high once the count reaches it. Sticky pending flags drive two interrupt lines, one for correctable events and one for uncorrectable events, each with its own enable. A master enable bit switches all collection on or off. Everything is reached through a 32-bit single-access register port: word index, write strobe, write data, and combinational read data.

Top module: `eccmon_top`

## Requirements
- R1: The corrected-error trace holds up to 4 addresses in arrival order. Reading word 2 returns the oldest address and removes it. When the trace is empty, word 2 reads 0 and status bit 4 is 1.
- R2: Every accepted cycle with `ev_ded` or `ev_aee` high logs `ev_addr` once into the uncorrectable trace (4 entries, arrival order). Reading word 3 returns the oldest entry and removes it. Status bit 5 is 1 when this trace is empty.
- R3: A corrected event whose address equals an entry currently held in the corrected-error trace is not logged again.
- R4: A new, non-duplicate entry that meets a full trace is dropped and sets a sticky overflow bit: status bit 2 for the corrected trace and bit 3 for the uncorrectable trace. Writing 1 to that bit of word 1 clears it.
- R5: Counters at words 4 (single-correct), 5 (double-detect) and 6 (address error) each add one per accepted event of their kind and hold at their all-ones maximum. Any write to a counter word clears that counter.
- R6: Words 7, 8 and 9 hold the thresholds for the counters at words 4, 5 and 6. `thr_exc[i]` is 1 exactly when threshold i is non-zero and counter i is greater than or equal to it.
- R7: When control bit 0 (word 0) is 0, the event inputs are ignored: no count, no trace entry and no pending flag.
- R8: Status bit 0 (correctable pending) and bit 1 (uncorrectable pending) are set by accepted events and cleared by writing 1 to them. `irq_corr` equals bit 0 ANDed with control bit 1. `irq_uncorr` equals bit 1 ANDed with control bit 2.
- R9: After reset, control reads 0, status reads 0x30, all counters and thresholds read 0, and both interrupts and `thr_exc` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_sec | input | 1 | Corrected single-bit error this cycle |
| ev_ded | input | 1 | Double-bit error detected this cycle |
| ev_aee | input | 1 | Address error detected this cycle |
| ev_addr | input | AW | Address of the reported access |
| reg_sel | input | 1 | Register access valid this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_idx | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_idx` |
| irq_corr | output | 1 | Correctable-error interrupt |
| irq_uncorr | output | 1 | Uncorrectable-error interrupt |
| thr_exc | output | 3 | Threshold reached: bit 0 single-correct, bit 1 double-detect, bit 2 address error |

## Verification
The hardest case to reach is a corrected trace that holds a mix of new and repeated addresses, because deduplication must compare against live entries only. The stimulus sends repeats both before and after the trace fills, and sends a fifth distinct address so the overflow flag is set while repeats are still being filtered out. Counter saturation needs many events, so the bench builds the block with narrow counters and drives a long run of address-error pulses.

// File: rtl/eccmon_pkg.sv
package eccmon_pkg;
  // Register word indices
  localparam int RI_CTRL  = 0;
  localparam int RI_STAT  = 1;
  localparam int RI_CHEAD = 2;
  localparam int RI_UHEAD = 3;
  localparam int RI_CNT0  = 4;  // counters occupy RI_CNT0 .. RI_CNT0+2
  localparam int RI_THR0  = 7;  // thresholds occupy RI_THR0 .. RI_THR0+2
  // Event lanes
  localparam int EV_SEC   = 0;
  localparam int EV_DED   = 1;
  localparam int EV_AEE   = 2;
  localparam int N_EV     = 3;
endpackage

// File: rtl/eccmon_trace_fifo.sv
module eccmon_trace_fifo #(
  parameter int DEPTH = 4,            // power of two, at least 2
  parameter int AW    = 16,
  parameter bit DEDUP = 1'b0,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [AW-1:0] addr,
  input  logic          pop,
  output logic [AW-1:0] head,
  output logic          empty,
  output logic [LW-1:0] level,
  output logic          dup,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          ovf_ev
);
  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic          full;

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);
  assign head  = mem[rd_ptr];

  generate
    if (DEDUP) begin : g_dedup
      logic hit;
      always_comb begin
        hit = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
          if (LW'(k) < level && mem[rd_ptr + PW'(k)] == addr) hit = 1'b1;
        end
      end
      assign dup = push_req & hit;
    end else begin : g_plain
      assign dup = 1'b0;
    end
  endgenerate

  assign push_ok = push_req & ~dup & ~full;
  assign ovf_ev  = push_req & ~dup & full;
  assign pop_ok  = pop & ~empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      level <= level + LW'(push_ok) - LW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= addr;
  end
endmodule

// File: rtl/eccmon_counter.sv
module eccmon_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          clr,
  input  logic [CW-1:0] thr,
  output logic [CW-1:0] cnt,
  output logic          hit
);
  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  function automatic logic reached(input logic [CW-1:0] c, input logic [CW-1:0] t);
    return (t != '0) && (c >= t);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= sat_inc(cnt);
  end

  assign hit = reached(cnt, thr);
endmodule

// File: rtl/eccmon_top.sv
module eccmon_top
  import eccmon_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CNT_W = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_sec,
  input  logic          ev_ded,
  input  logic          ev_aee,
  input  logic [AW-1:0] ev_addr,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [3:0]    reg_idx,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq_corr,
  output logic          irq_uncorr,
  output logic [2:0]    thr_exc
);
  localparam int LW = $clog2(DEPTH) + 1;

  // Control and status state
  logic diag_en, ie_corr, ie_unc;
  logic pend_c, pend_u, ovf_c, ovf_u;

  // Named internal events
  logic            wr_en, rd_en, stat_wr;
  logic            sec_acc, unc_acc;
  logic [N_EV-1:0] ev_acc, clr_vec, thr_wr;
  logic            corr_pop_req, unc_pop_req;
  logic            corr_push, corr_dup, corr_pop, corr_ovf, corr_empty;
  logic            unc_push, unc_dup, unc_pop, unc_ovf, unc_empty;
  logic [LW-1:0]   corr_level, unc_level;
  logic [AW-1:0]   corr_head, unc_head;
  logic [CNT_W-1:0] cnt_q [N_EV];
  logic [CNT_W-1:0] thr_q [N_EV];
  logic [CNT_W-1:0] cnt_sec;
  logic            unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign wr_en   = reg_sel & reg_wr;
  assign rd_en   = reg_sel & ~reg_wr;
  assign stat_wr = wr_en & (reg_idx == 4'(RI_STAT));

  assign ev_acc  = {ev_aee, ev_ded, ev_sec} & {N_EV{diag_en}};
  assign sec_acc = ev_acc[EV_SEC];
  assign unc_acc = ev_acc[EV_DED] | ev_acc[EV_AEE];

  assign corr_pop_req = rd_en & (reg_idx == 4'(RI_CHEAD));
  assign unc_pop_req  = rd_en & (reg_idx == 4'(RI_UHEAD));

  eccmon_trace_fifo #(.DEPTH(DEPTH), .AW(AW), .DEDUP(1'b1)) u_corr_fifo (
    .clk(clk), .rst_n(rst_n), .push_req(sec_acc), .addr(ev_addr),
    .pop(corr_pop_req), .head(corr_head), .empty(corr_empty),
    .level(corr_level), .dup(corr_dup), .push_ok(corr_push),
    .pop_ok(corr_pop), .ovf_ev(corr_ovf)
  );

  eccmon_trace_fifo #(.DEPTH(DEPTH), .AW(AW), .DEDUP(1'b0)) u_unc_fifo (
    .clk(clk), .rst_n(rst_n), .push_req(unc_acc), .addr(ev_addr),
    .pop(unc_pop_req), .head(unc_head), .empty(unc_empty),
    .level(unc_level), .dup(unc_dup), .push_ok(unc_push),
    .pop_ok(unc_pop), .ovf_ev(unc_ovf)
  );

  // Counters and thresholds, one lane per event kind
  generate
    for (genvar i = 0; i < N_EV; i++) begin : g_lane
      assign clr_vec[i] = wr_en & (reg_idx == 4'(RI_CNT0 + i));
      assign thr_wr[i]  = wr_en & (reg_idx == 4'(RI_THR0 + i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         thr_q[i] <= '0;
        else if (thr_wr[i]) thr_q[i] <= reg_wdata[CNT_W-1:0];
      end

      eccmon_counter #(.CW(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(ev_acc[i]), .clr(clr_vec[i]),
        .thr(thr_q[i]), .cnt(cnt_q[i]), .hit(thr_exc[i])
      );
    end
  endgenerate

  assign cnt_sec = cnt_q[EV_SEC];

  // Control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ie_unc, ie_corr, diag_en} <= 3'b000;
    end else if (wr_en && reg_idx == 4'(RI_CTRL)) begin
      {ie_unc, ie_corr, diag_en} <= reg_wdata[2:0];
    end
  end

  // Sticky status: a set in the same cycle wins over write-1-to-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ovf_u, ovf_c, pend_u, pend_c} <= 4'b0000;
    end else begin
      pend_c <= sec_acc  | (pend_c & ~(stat_wr & reg_wdata[0]));
      pend_u <= unc_acc  | (pend_u & ~(stat_wr & reg_wdata[1]));
      ovf_c  <= corr_ovf | (ovf_c  & ~(stat_wr & reg_wdata[2]));
      ovf_u  <= unc_ovf  | (ovf_u  & ~(stat_wr & reg_wdata[3]));
    end
  end

  assign irq_corr   = pend_c & ie_corr;
  assign irq_uncorr = pend_u & ie_unc;

  // Read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_idx)
      4'(RI_CTRL):    reg_rdata = {29'd0, ie_unc, ie_corr, diag_en};
      4'(RI_STAT):    reg_rdata = {26'd0, unc_empty, corr_empty, ovf_u, ovf_c, pend_u, pend_c};
      4'(RI_CHEAD):   reg_rdata = corr_empty ? '0 : 32'(corr_head);
      4'(RI_UHEAD):   reg_rdata = unc_empty  ? '0 : 32'(unc_head);
      4'(RI_CNT0):    reg_rdata = 32'(cnt_q[0]);
      4'(RI_CNT0+1):  reg_rdata = 32'(cnt_q[1]);
      4'(RI_CNT0+2):  reg_rdata = 32'(cnt_q[2]);
      4'(RI_THR0):    reg_rdata = 32'(thr_q[0]);
      4'(RI_THR0+1):  reg_rdata = 32'(thr_q[1]);
      4'(RI_THR0+2):  reg_rdata = 32'(thr_q[2]);
      default:        reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/eccmon_chk.sv
module eccmon_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 16,
  parameter int LW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          diag_en,
  input logic [LW-1:0] corr_level,
  input logic [LW-1:0] unc_level,
  input logic          corr_dup,
  input logic          corr_pop,
  input logic          unc_push,
  input logic          unc_pop,
  input logic [CW-1:0] cnt_sec,
  input logic [2:0]    clr_vec,
  input logic          stat_wr,
  input logic          ovf_c
);
  AST_CORR_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    corr_level <= LW'(DEPTH)); // R1
  AST_UNC_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    unc_push && !unc_pop |=> unc_level == LW'($past(unc_level) + 1'b1)); // R2
  AST_DUP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    corr_dup && !corr_pop |=> $stable(corr_level)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_c && !stat_wr |=> ovf_c); // R4
  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_sec == '1 && !clr_vec[0] |=> cnt_sec == '1); // R5
  AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !diag_en && !clr_vec[0] |=> $stable(cnt_sec)); // R7
endmodule

bind eccmon_top eccmon_chk #(.DEPTH(DEPTH), .CW(CNT_W), .LW($clog2(DEPTH) + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .diag_en(diag_en), .corr_level(corr_level),
  .unc_level(unc_level), .corr_dup(corr_dup), .corr_pop(corr_pop),
  .unc_push(unc_push), .unc_pop(unc_pop), .cnt_sec(cnt_sec),
  .clr_vec(clr_vec), .stat_wr(stat_wr), .ovf_c(ovf_c)
);

// File: tb/eccmon_top_tb.sv
`timescale 1ns/1ps
module eccmon_top_tb;
  localparam int AW = 16;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_sec = 0, ev_ded = 0, ev_aee = 0;
  logic [AW-1:0] ev_addr = '0;
  logic reg_sel = 0, reg_wr = 0;
  logic [3:0] reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_corr, irq_uncorr;
  logic [2:0] thr_exc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  eccmon_top #(.AW(AW), .CNT_W(CW), .DEPTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_sec(ev_sec), .ev_ded(ev_ded), .ev_aee(ev_aee),
    .ev_addr(ev_addr), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_corr(irq_corr),
    .irq_uncorr(irq_uncorr), .thr_exc(thr_exc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_idx = 4'(idx); reg_wdata = d;
    @(posedge clk); #1;
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 0; reg_idx = 4'(idx);
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_sel = 0;
  endtask

  task automatic ev(input logic s, input logic d, input logic a, input logic [AW-1:0] ad);
    @(negedge clk);
    ev_sec = s; ev_ded = d; ev_aee = a; ev_addr = ad;
    @(posedge clk); #1;
    ev_sec = 0; ev_ded = 0; ev_aee = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v); chk("R9 ctrl", v, 0);
    rd(1, v); chk("R9 status", v, 32'h30);
    rd(4, v); chk("R9 cnt", v, 0);
    rd(7, v); chk("R9 thr", v, 0);
    chk("R9 irq", {30'd0, irq_uncorr, irq_corr}, 0);
    chk("R9 thr_exc", 32'(thr_exc), 0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    ev(1, 1, 1, 16'h0042);
    ev(1, 0, 0, 16'h0043);
    rd(4, v); chk("R7 sec cnt frozen", v, 0);
    rd(6, v); chk("R7 aee cnt frozen", v, 0);
    rd(1, v); chk("R7 status untouched", v, 32'h30);
    rd(2, v); chk("R7 corr trace empty", v, 0);
  endtask

  task automatic t_order();
    logic [31:0] v;
    ev(1, 0, 0, 16'h1111);
    ev(1, 0, 0, 16'h2222);
    rd(1, v); chk("R1 not empty", v & 32'h10, 0);
    rd(2, v); chk("R1 head0", v, 32'h1111);
    rd(2, v); chk("R1 head1", v, 32'h2222);
    rd(1, v); chk("R1 empty bit", v & 32'h10, 32'h10);
    rd(2, v); chk("R1 empty read", v, 0);
  endtask

  task automatic t_dedup();
    logic [31:0] v;
    wr(4, 0);
    ev(1, 0, 0, 16'h0AA0);
    ev(1, 0, 0, 16'h0AA0);
    ev(1, 0, 0, 16'h0BB0);
    ev(1, 0, 0, 16'h0AA0);
    rd(4, v); chk("R5 sec counts repeats", v, 4);
    rd(2, v); chk("R3 first", v, 32'h0AA0);
    rd(2, v); chk("R3 second", v, 32'h0BB0);
    rd(1, v); chk("R3 no third entry", v & 32'h10, 32'h10);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    wr(1, 32'h3);
    for (int i = 0; i < 5; i++) ev(1, 0, 0, 16'(16'h0100 + i));
    ev(1, 0, 0, 16'h0102);  // duplicate of a held entry while full
    rd(1, v); chk("R4 ovf set", v & 32'h4, 32'h4);
    for (int i = 0; i < 4; i++) begin
      rd(2, v); chk("R4 kept entry", v, 32'(16'h0100 + i));
    end
    rd(1, v); chk("R4 fifth dropped", v & 32'h10, 32'h10);
    rd(1, v); chk("R4 ovf sticky", v & 32'h4, 32'h4);
    wr(1, 32'h4);
    rd(1, v); chk("R4 ovf cleared", v & 32'h4, 0);
  endtask

  task automatic t_unc();
    logic [31:0] v;
    wr(5, 0); wr(6, 0);
    ev(0, 1, 0, 16'h3000);
    ev(0, 0, 1, 16'h3001);
    ev(0, 1, 1, 16'h3002);
    rd(5, v); chk("R5 ded cnt", v, 2);
    rd(6, v); chk("R5 aee cnt", v, 2);
    rd(1, v); chk("R2 unc not empty", v & 32'h20, 0);
    rd(3, v); chk("R2 head0", v, 32'h3000);
    rd(3, v); chk("R2 head1", v, 32'h3001);
    rd(3, v); chk("R2 head2 single entry", v, 32'h3002);
    rd(1, v); chk("R2 unc empty", v & 32'h20, 32'h20);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(1, 32'hF);
    chk("R8 irq low after clear", {30'd0, irq_uncorr, irq_corr}, 0);
    ev(1, 0, 0, 16'h5000);
    chk("R8 irq_corr raised", 32'(irq_corr), 1);
    chk("R8 irq_uncorr quiet", 32'(irq_uncorr), 0);
    wr(1, 32'h1);
    chk("R8 irq_corr cleared", 32'(irq_corr), 0);
    wr(0, 32'h1);
    ev(0, 1, 0, 16'h5001);
    chk("R8 masked irq", 32'(irq_uncorr), 0);
    rd(1, v); chk("R8 pending while masked", v & 32'h2, 32'h2);
    wr(0, 32'h7);
    chk("R8 unmasked irq", 32'(irq_uncorr), 1);
    wr(1, 32'hF);
  endtask

  task automatic t_thresh();
    wr(7, 3); wr(4, 0);
    ev(1, 0, 0, 16'h6000);
    ev(1, 0, 0, 16'h6000);
    chk("R6 below thr", 32'(thr_exc[0]), 0);
    ev(1, 0, 0, 16'h6000);
    chk("R6 at thr", 32'(thr_exc[0]), 1);
    wr(7, 0);
    chk("R6 zero thr off", 32'(thr_exc[0]), 0);
    wr(8, 1); wr(5, 0);
    chk("R6 ded below", 32'(thr_exc[1]), 0);
    ev(0, 1, 0, 16'h6001);
    chk("R6 ded reached", 32'(thr_exc[1]), 1);
  endtask

  task automatic t_sat();
    logic [31:0] v;
    wr(6, 0);
    for (int i = 0; i < 20; i++) ev(0, 0, 1, 16'h7000);
    rd(6, v); chk("R5 saturate", v, 32'hF);
    wr(6, 0);
    rd(6, v); chk("R5 write clears", v, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_disabled();
    wr(0, 32'h7);
    t_order();
    t_dedup();
    t_overflow();
    t_unc();
    t_irq();
    t_thresh();
    t_sat();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule